// File: doc/BRIEF.md
# Quarter-Wave Sine/Cosine Waveform Mapper

This block turns a 16-bit phase word into four signed 16-bit samples at once: a sine, a cosine a quarter turn ahead of it, a square wave and a sawtooth. It sits behind a phase accumulator in a digital oscillator. The magnitude table outside the block holds only the first quarter of a sine period. The block folds each phase into that quarter: it mirrors the table index in the second and fourth quadrants and negates the result in the lower half of the cycle. This rebuilds the full period from the stored quarter.

The table is a dual-read, combinational lookup outside the block. The block drives one index for the sine and one for the cosine from a register. It takes the two magnitudes back in the next cycle. A parameter picks the resolution. With the full setting, all 16 phase bits are used, the index is 14 bits wide and the magnitudes are 15 bits. With the reduced setting, only the top 12 phase bits are used, the index is 10 bits wide and the magnitudes are 11 bits. The reduced magnitudes are aligned to the top of the 15-bit magnitude field. The table contents are computed outside the block.

The datapath has two register stages, both gated by a clock enable, so a low enable freezes the whole pipeline in place. Reset is synchronous and active high.

Top module: `wave_quad_mapper`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears `sin_out`, `cos_out`, `squ_out`, `saw_out`, `sin_addr` and `cos_addr` to zero.
- R2: Take P as the top LUT_BITS bits of the phase. Its top bit is the half bit H, the next bit is the fold bit F, and the remaining LUT_BITS-2 bits are the low field L. The sine index is L when F is 0 and the bitwise complement of L when F is 1. The sine sample is the aligned magnitude when H is 0 and its two's-complement negation when H is 1.
- R3: The cosine uses the rule of R2, applied to P plus one quarter turn (1 shifted left by LUT_BITS-2, modulo 2^LUT_BITS).
- R4: `squ_out` is +32767 (0x7FFF) when phase bit 15 is 0 and −32768 (0x8000) when it is 1.
- R5: `saw_out` equals the 16-bit phase with bit 15 inverted, read as a signed number.
- R6: A phase captured at an enabled edge drives `sin_addr`/`cos_addr` after that edge. Its four samples appear after the next enabled edge, using the magnitudes present on `sin_mag`/`cos_mag` in the cycle between those two edges.
- R7: An edge with `en` low changes no output and no table index. When `en` returns high, the pipeline continues with the next sample in order, skipping none and repeating none.
- R8: With LUT_BITS = 12, phase bits 15..4 form P, the indices are 10 bits wide, and the 11-bit magnitude is shifted left by 4 before the sign is applied.
- R9: With LUT_BITS = 16, all 16 phase bits form P, the indices are 14 bits wide, and the 15-bit magnitude is used without shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for both pipeline stages |
| phase_in | input | 16 | Unsigned phase word, full turn = 2^16 |
| sin_addr | output | LUT_BITS-2 | Quarter-table index for the sine |
| cos_addr | output | LUT_BITS-2 | Quarter-table index for the cosine |
| sin_mag | input | LUT_BITS-1 | Unsigned magnitude read at `sin_addr` |
| cos_mag | input | LUT_BITS-1 | Unsigned magnitude read at `cos_addr` |
| sin_out | output | 16 | Signed sine sample |
| cos_out | output | 16 | Signed cosine sample |
| squ_out | output | 16 | Signed square-wave sample |
| saw_out | output | 16 | Signed sawtooth sample |

## Verification
Each fold and sign case is driven with phases at both ends of all four quadrants (0x0000, 0x3FFF, 0x4000, 0x7FFF, 0x8000, 0xBFFF, 0xC000, 0xFFFF). These tell a correct mirror apart from an off-by-one index or a swapped sign. Mid-quadrant and irregular phases such as 0x1234 and 0xA5A5 show that the low bits pass unchanged into the index. The same phases go to a reduced instance and a full instance at the same time, so a wrong alignment shift or a wrong choice of phase bits shows as a mismatch in one mode only. A single step in phase and a burst of stalled edges separate the address stage from the output stage. They also show whether the first sample after resuming is the one held back, not a skipped or a repeated one.

// File: rtl/wqm_pkg.sv
package wqm_pkg;

    localparam int PHASE_W  = 16;
    localparam int SAMPLE_W = 16;
    localparam int MAGF_W   = SAMPLE_W - 1;

    typedef logic signed [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t squ;
        sample_t saw;
    } shape_t;

    localparam sample_t SQUARE_HI = 16'sh7FFF;
    localparam sample_t SQUARE_LO = 16'sh8000;

    // Square and sawtooth values for one phase word
    function automatic shape_t shape_of(input logic [PHASE_W-1:0] ph);
        shape_t s;
        s.squ = ph[PHASE_W-1] ? SQUARE_LO : SQUARE_HI;
        s.saw = sample_t'({~ph[PHASE_W-1], ph[PHASE_W-2:0]});
        return s;
    endfunction

    // Apply the half-cycle sign to a 15-bit magnitude
    function automatic sample_t signed_mag(input logic [MAGF_W-1:0] mag,
                                           input logic neg);
        logic [SAMPLE_W-1:0] pos;
        pos = {1'b0, mag};
        return neg ? sample_t'(~pos + 1'b1) : sample_t'(pos);
    endfunction

endpackage

// File: rtl/wqm_channel.sv
module wqm_channel
    import wqm_pkg::*;
#(
    parameter int LUT_BITS = 12,
    parameter bit QUARTER  = 1'b0,
    localparam int PH_W  = LUT_BITS,
    localparam int QA_W  = LUT_BITS - 2,
    localparam int MAG_W = LUT_BITS - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PH_W-1:0]  phase,
    output logic [QA_W-1:0]  addr,
    input  logic [MAG_W-1:0] mag,
    output sample_t          sample
);

    localparam logic [PH_W-1:0] OFFSET = QUARTER ? (PH_W'(1) << (PH_W - 2)) : '0;
    localparam int PAD_W = MAGF_W - MAG_W;

    typedef struct packed {
        logic [QA_W-1:0] idx;
        logic            neg;
    } fold_t;

    logic [PH_W-1:0]   ph_rot;
    fold_t             fold_d;
    fold_t             fold_q;
    logic [MAGF_W-1:0] mag_full;

    // Stage 0: rotate by the channel offset and fold into one quadrant
    always_comb begin
        ph_rot      = phase + OFFSET;
        fold_d.neg  = ph_rot[PH_W-1];
        fold_d.idx  = ph_rot[PH_W-2] ? ~ph_rot[QA_W-1:0] : ph_rot[QA_W-1:0];
    end

    // Align the stored magnitude to the top of the 15-bit field
    generate
        if (PAD_W == 0) begin : g_full_mag
            assign mag_full = mag;
        end else begin : g_pad_mag
            assign mag_full = {mag, {PAD_W{1'b0}}};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            fold_q <= '0;
            sample <= '0;
        end else if (en) begin
            fold_q <= fold_d;
            sample <= signed_mag(mag_full, fold_q.neg);
        end
    end

    assign addr = fold_q.idx;

endmodule

// File: rtl/wqm_shape_pipe.sv
module wqm_shape_pipe
    import wqm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] phase,
    output sample_t            squ,
    output sample_t            saw
);

    localparam int DEPTH = 2;

    shape_t stage_q [DEPTH];

    genvar gs;
    generate
        for (gs = 0; gs < DEPTH; gs++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[gs] <= '0;
                end else if (en) begin
                    if (gs == 0) begin
                        stage_q[gs] <= shape_of(phase);
                    end else begin
                        stage_q[gs] <= stage_q[gs-1];
                    end
                end
            end
        end
    endgenerate

    assign squ = stage_q[DEPTH-1].squ;
    assign saw = stage_q[DEPTH-1].saw;

endmodule

// File: rtl/wave_quad_mapper.sv
module wave_quad_mapper
    import wqm_pkg::*;
#(
    parameter int LUT_BITS = 12,
    localparam int QA_W  = LUT_BITS - 2,
    localparam int MAG_W = LUT_BITS - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [15:0]        phase_in,
    output logic [QA_W-1:0]    sin_addr,
    output logic [QA_W-1:0]    cos_addr,
    input  logic [MAG_W-1:0]   sin_mag,
    input  logic [MAG_W-1:0]   cos_mag,
    output logic signed [15:0] sin_out,
    output logic signed [15:0] cos_out,
    output logic signed [15:0] squ_out,
    output logic signed [15:0] saw_out
);

    localparam int NCH = 2;

    logic [LUT_BITS-1:0] ph_top;
    logic [QA_W-1:0]     addr_w [NCH];
    logic [MAG_W-1:0]    mag_w  [NCH];
    sample_t             samp_w [NCH];

    assign ph_top   = phase_in[PHASE_W-1 -: LUT_BITS];
    assign mag_w[0] = sin_mag;
    assign mag_w[1] = cos_mag;

    // Channel 0 is the sine, channel 1 the cosine (a quarter turn ahead)
    genvar gc;
    generate
        for (gc = 0; gc < NCH; gc++) begin : g_ch
            wqm_channel #(
                .LUT_BITS (LUT_BITS),
                .QUARTER  (gc == 1)
            ) u_ch (
                .clk    (clk),
                .rst    (rst),
                .en     (en),
                .phase  (ph_top),
                .addr   (addr_w[gc]),
                .mag    (mag_w[gc]),
                .sample (samp_w[gc])
            );
        end
    endgenerate

    wqm_shape_pipe u_shape (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .phase (phase_in),
        .squ   (squ_out),
        .saw   (saw_out)
    );

    assign sin_addr = addr_w[0];
    assign cos_addr = addr_w[1];
    assign sin_out  = samp_w[0];
    assign cos_out  = samp_w[1];

endmodule

// File: rtl/wave_quad_mapper_chk.sv
module wave_quad_mapper_chk #(
    parameter int QA_W = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic [QA_W-1:0]    sin_addr,
    input logic [QA_W-1:0]    cos_addr,
    input logic signed [15:0] sin_out,
    input logic signed [15:0] cos_out,
    input logic signed [15:0] squ_out,
    input logic signed [15:0] saw_out
);

    // Enabled edges since reset, saturating once the pipeline is full
    logic [1:0] fill;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= 2'd0;
        end else if (en && fill != 2'd2) begin
            fill <= fill + 2'd1;
        end
    end

    // R1: a reset edge clears every output and index
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (sin_out == 16'sd0 && cos_out == 16'sd0 && squ_out == 16'sd0 &&
                 saw_out == 16'sd0 && sin_addr == '0 && cos_addr == '0));

    // R7: a disabled edge changes nothing
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(sin_out) && $stable(cos_out) && $stable(squ_out) &&
                 $stable(saw_out) && $stable(sin_addr) && $stable(cos_addr)));

    // R4: square level agrees with the half of the cycle seen on the sawtooth
    p_square_level_r4: assert property (@(posedge clk) disable iff (rst)
        (fill == 2'd2) |-> (squ_out == (saw_out[15] ? 16'sh7FFF : 16'sh8000)));

    // R2: sine sign follows the half bit
    p_sine_sign_r2: assert property (@(posedge clk) disable iff (rst)
        (fill == 2'd2) |-> (saw_out[15] ? (sin_out >= 0) : (sin_out <= 0)));

    // R3: cosine is non-negative in the first and last quadrants only
    p_cos_sign_r3: assert property (@(posedge clk) disable iff (rst)
        (fill == 2'd2) |-> ((saw_out[15] != saw_out[14]) ? (cos_out >= 0) : (cos_out <= 0)));

endmodule

bind wave_quad_mapper wave_quad_mapper_chk #(.QA_W(QA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .sin_addr (sin_addr),
    .cos_addr (cos_addr),
    .sin_out  (sin_out),
    .cos_out  (cos_out),
    .squ_out  (squ_out),
    .saw_out  (saw_out)
);

// File: tb/wave_quad_mapper_test.sv
`timescale 1ns/1ps
module wave_quad_mapper_test;

    localparam real PI = 3.14159265358979;
    localparam int  NVEC = 12;
    localparam logic [15:0] VEC [NVEC] = '{
        16'h0000, 16'h3FFF, 16'h4000, 16'h7FFF, 16'h8000, 16'hBFFF,
        16'hC000, 16'hFFFF, 16'h2000, 16'h1234, 16'hA5A5, 16'h0010
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b1;
    logic [15:0] phase_in = 16'h1234;

    logic [9:0]  r_sin_addr, r_cos_addr;
    logic [10:0] r_sin_mag, r_cos_mag;
    logic signed [15:0] r_sin, r_cos, r_squ, r_saw;

    logic [13:0] f_sin_addr, f_cos_addr;
    logic [14:0] f_sin_mag, f_cos_mag;
    logic signed [15:0] f_sin, f_cos, f_squ, f_saw;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    // Quarter-wave magnitude, sampled at half-step offsets
    function automatic int qmag(input int idx, input int bits);
        int  n;
        real full;
        n    = 1 << (bits - 2);
        full = real'((1 << (bits - 1)) - 1);
        return int'(full * $sin(PI / 2.0 * (real'(idx) + 0.5) / real'(n)));
    endfunction

    function automatic int exp_addr(input logic [15:0] p, input int bits, input bit quarter);
        int ph, n, low;
        n  = 1 << (bits - 2);
        ph = int'(p) >> (16 - bits);
        if (quarter) ph = (ph + n) % (1 << bits);
        low = ph % n;
        return (((ph >> (bits - 2)) & 1) != 0) ? (n - 1 - low) : low;
    endfunction

    function automatic int exp_wave(input logic [15:0] p, input int bits, input bit quarter);
        int ph, m;
        ph = int'(p) >> (16 - bits);
        if (quarter) ph = (ph + (1 << (bits - 2))) % (1 << bits);
        m = qmag(exp_addr(p, bits, quarter), bits) << (16 - bits);
        return ((ph >> (bits - 1)) != 0) ? -m : m;
    endfunction

    // Table models
    always_comb begin
        r_sin_mag = 11'(qmag(int'(r_sin_addr), 12));
        r_cos_mag = 11'(qmag(int'(r_cos_addr), 12));
        f_sin_mag = 15'(qmag(int'(f_sin_addr), 16));
        f_cos_mag = 15'(qmag(int'(f_cos_addr), 16));
    end

    wave_quad_mapper #(.LUT_BITS(12)) uut (
        .clk(clk), .rst(rst), .en(en), .phase_in(phase_in),
        .sin_addr(r_sin_addr), .cos_addr(r_cos_addr),
        .sin_mag(r_sin_mag), .cos_mag(r_cos_mag),
        .sin_out(r_sin), .cos_out(r_cos), .squ_out(r_squ), .saw_out(r_saw)
    );

    wave_quad_mapper #(.LUT_BITS(16)) uut_full (
        .clk(clk), .rst(rst), .en(en), .phase_in(phase_in),
        .sin_addr(f_sin_addr), .cos_addr(f_cos_addr),
        .sin_mag(f_sin_mag), .cos_mag(f_cos_mag),
        .sin_out(f_sin), .cos_out(f_cos), .squ_out(f_squ), .saw_out(f_saw)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all_outputs(input logic [15:0] p, input string tag);
        chk({"R2 R8 sine ", tag}, int'(r_sin), exp_wave(p, 12, 1'b0));
        chk({"R3 R8 cosine ", tag}, int'(r_cos), exp_wave(p, 12, 1'b1));
        chk({"R4 square ", tag}, int'(r_squ), p[15] ? -32768 : 32767);
        chk({"R5 sawtooth ", tag}, int'(r_saw), int'($signed(p ^ 16'h8000)));
        chk({"R9 full sine ", tag}, int'(f_sin), exp_wave(p, 16, 1'b0));
        chk({"R9 full cosine ", tag}, int'(f_cos), exp_wave(p, 16, 1'b1));
        chk({"R4 R5 full shapes ", tag}, int'(f_squ) + int'(f_saw), int'(r_squ) + int'(r_saw));
    endtask

    task automatic check_reset_state(input string tag);
        chk({"R1 outputs zero ", tag},
            int'(r_sin != 0) + int'(r_cos != 0) + int'(r_squ != 0) + int'(r_saw != 0) +
            int'(f_sin != 0) + int'(f_cos != 0) + int'(f_squ != 0) + int'(f_saw != 0), 0);
        chk({"R1 indices zero ", tag},
            int'(r_sin_addr) + int'(r_cos_addr) + int'(f_sin_addr) + int'(f_cos_addr), 0);
    endtask

    initial begin : watchdog
        #(20.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] pa, pb, pprev;

        // R1: reset with a nonzero phase applied
        step(3);
        check_reset_state("initial");
        rst = 1'b0;

        // R2 R3 R4 R5 R8 R9: vector walk
        for (int v = 0; v < NVEC; v++) begin
            phase_in = VEC[v];
            step(2);
            check_all_outputs(VEC[v], $sformatf("phase %h", VEC[v]));
        end

        // R6: latency of the index and of the samples
        pprev    = VEC[NVEC-1];
        pa       = 16'h6ABC;
        phase_in = pa;
        step(1);
        chk("R6 index after first edge", int'(r_sin_addr), exp_addr(pa, 12, 1'b0));
        chk("R6 cos index after first edge", int'(f_cos_addr), exp_addr(pa, 16, 1'b1));
        chk("R6 sample not yet updated", int'(r_sin), exp_wave(pprev, 12, 1'b0));
        step(1);
        chk("R6 sample after second edge", int'(r_sin), exp_wave(pa, 12, 1'b0));

        // R7: stall and resume
        pprev    = pa;
        pa       = 16'hD00D;
        pb       = 16'h3333;
        phase_in = pa;
        step(1);
        en       = 1'b0;
        phase_in = pb;
        step(3);
        chk("R7 sine held", int'(r_sin), exp_wave(pprev, 12, 1'b0));
        chk("R7 square held", int'(f_squ), pprev[15] ? -32768 : 32767);
        chk("R7 index held", int'(r_sin_addr), exp_addr(pa, 12, 1'b0));
        en = 1'b1;
        step(1);
        chk("R7 first sample after resume", int'(r_sin), exp_wave(pa, 12, 1'b0));
        chk("R7 first full sample after resume", int'(f_cos), exp_wave(pa, 16, 1'b1));
        step(1);
        chk("R7 next sample after resume", int'(r_sin), exp_wave(pb, 12, 1'b0));
        chk("R7 sawtooth after resume", int'(r_saw), int'($signed(pb ^ 16'h8000)));

        // R1: reset in mid-run
        rst = 1'b1;
        step(1);
        check_reset_state("mid-run");
        rst = 1'b0;
        step(2);
        check_all_outputs(pb, "after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule